// File: doc/BRIEF.md
# Serial Ethernet Frame Receive Parser

This block receives an Ethernet frame as a raw bit-serial stream, one bit per clock while a valid strobe is high. Octets travel least significant bit first. Once it is armed, the block looks for the run of preamble octets and the start-of-frame delimiter, packs the bits that follow into octets, and splits the frame into its header fields and its body. It reports the destination address, the source address and the type/length value with a one-cycle header strobe. It also classifies the type value and spots SNAP encapsulation.

Every octet after the header leaves on a byte-wide valid/last stream. A four-entry delay line holds the most recent four octets until the line goes idle. Those four octets then leave back to back, tagged as frame check octets, so a downstream CRC checker can consume them. When the frame ends, the block reports the octet count and an error flag. It does not verify the CRC.

A pulse-level consumer connects to the stream and the two strobes. The frame boundary is the falling edge of the valid strobe. After any frame ends or is rejected, the block needs 12 octet-times of idle line before it accepts another preamble.

Top module: `eth_rx_parser`

## Requirements
- R1: After reset and after every frame or abandoned hunt, the block ignores a preamble unless `rx_vld_i` was low for at least 96 consecutive clocks just before it. Exactly 96 is enough; 95 is not.
- R2: Bits are packed LSB first, so the first bit received lands in bit 0. A frame is accepted only after exactly seven 0x55 octets followed by 0xD5. Any other octet during the hunt, an early 0xD5 or an eighth 0x55 abandons the frame with no output at all.
- R3: The first 14 octets after the delimiter are captured as the destination address (6 octets), the source address (6 octets) and the type/length (2 octets). In each field the first octet received is the most significant byte. `hdr_vld_o` pulses once after the 14th octet.
- R4: When `hdr_vld_o` is high, `is_ipv4_o` is 1 exactly when the type is 0x0800 and `is_arp_o` is 1 exactly when it is 0x0806. The two are never high together.
- R5: `is_snap_o` is 1 at `cnt_vld_o` exactly when octets 15 and 16 after the delimiter are both 0xAA. A single 0xAA does not set it.
- R6: Every octet after the header is output once, in order, on `data_o` with `data_vld_o`. All but the final four have `data_fcs_o` low.
- R7: The final four octets before idle are output on consecutive clocks with `data_fcs_o` high. `data_last_o` is high only on the fourth of them.
- R8: `cnt_vld_o` pulses with the last beat. While it is high, `octet_cnt_o` equals the number of whole octets from the first octet after the delimiter through the last check octet.
- R9: `data_err_o`, valid with `cnt_vld_o`, is 1 when the count is below 64 or above 1518. Those bounds come from a payload of 46 to 1500 octets.
- R10: If valid drops in the middle of an octet, the partial bits are discarded, the count covers only whole octets, and `data_err_o` is 1.
- R11: `hdr_vld_o` and `cnt_vld_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_bit_i | input | 1 | Serial data bit |
| rx_vld_i | input | 1 | Bit valid; low means idle line |
| hdr_vld_o | output | 1 | Header fields valid pulse |
| dst_addr_o | output | 48 | Destination address |
| src_addr_o | output | 48 | Source address |
| type_len_o | output | 16 | Type/length field |
| is_ipv4_o | output | 1 | Type is 0x0800 |
| is_arp_o | output | 1 | Type is 0x0806 |
| is_snap_o | output | 1 | Both octets after type are 0xAA |
| data_o | output | 8 | Body octet |
| data_vld_o | output | 1 | Body octet valid |
| data_fcs_o | output | 1 | Octet is one of the final four |
| data_last_o | output | 1 | Final octet of the frame |
| data_err_o | output | 1 | Frame error, qualified by cnt_vld_o |
| octet_cnt_o | output | 16 | Octets after the delimiter |
| cnt_vld_o | output | 1 | Count and error valid pulse |

## Verification
The parser is driven with frames of fixed and random content. Frames at 63, 64, 1518 and 1519 octets separate the error-free length range from the flagged one. IPv4, ARP, SNAP, single-0xAA and plain length-type frames separate the classification outputs from one another, and a frame cut off three bits into an octet checks partial-octet handling. Preambles that are short, long or end in a bad delimiter must produce no output at all. A 95-clock and a 96-clock idle gap before a frame confirm the exact re-arm threshold.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {ST_GAP, ST_HUNT, ST_BODY} rx_state_e;
  localparam logic [7:0]  PRE_OCT  = 8'h55;
  localparam logic [7:0]  SFD_OCT  = 8'hD5;
  localparam logic [7:0]  SNAP_OCT = 8'hAA;
  localparam logic [15:0] TYPE_IPV4 = 16'h0800;
  localparam logic [15:0] TYPE_ARP  = 16'h0806;
endpackage

// File: rtl/eth_rx_deser.sv
module eth_rx_deser #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         vld_i,
  output logic [W-1:0] oct_o,
  output logic         oct_vld_o,
  output logic         end_o,
  output logic         part_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          vld_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      vld_d_q   <= 1'b0;
      oct_o     <= '0;
      oct_vld_o <= 1'b0;
      end_o     <= 1'b0;
      part_o    <= 1'b0;
    end else begin
      vld_d_q   <= vld_i;
      oct_vld_o <= 1'b0;
      end_o     <= 1'b0;
      if (vld_i) begin
        sr_q  <= {bit_i, sr_q[W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          oct_vld_o <= 1'b1;
          oct_o     <= {bit_i, sr_q[W-1:1]};
        end
      end else begin
        cnt_q <= '0;
        if (vld_d_q) begin
          end_o  <= 1'b1;
          part_o <= (cnt_q != '0);
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_gap.sv
module eth_rx_gap #(
  parameter int LIMIT = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  output logic done_o
);
  localparam int GW = $clog2(LIMIT + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (vld_i)                 cnt_q <= '0;
    else if (cnt_q != GW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == GW'(LIMIT));
endmodule

// File: rtl/eth_rx_dly.sv
module eth_rx_dly #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          flush_i,
  output logic [W-1:0]  dout_o,
  output logic          vld_o,
  output logic          fcs_o,
  output logic          last_o,
  output logic [OW-1:0] occ_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [OW-1:0] occ_q;
  logic          flushing_q;
  logic          full;
  logic          drain;

  assign full  = (occ_q == OW'(DEPTH));
  assign drain = !push_i && (flush_i || flushing_q) && (occ_q != '0);
  assign occ_o = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q      <= '0;
      flushing_q <= 1'b0;
      dout_o     <= '0;
      vld_o      <= 1'b0;
      fcs_o      <= 1'b0;
      last_o     <= 1'b0;
    end else begin
      vld_o      <= 1'b0;
      fcs_o      <= 1'b0;
      last_o     <= 1'b0;
      flushing_q <= (flush_i || flushing_q) && (occ_q > OW'(1));
      if (push_i) begin
        if (full) begin
          vld_o  <= 1'b1;
          dout_o <= mem_q[0];
        end else begin
          occ_q <= occ_q + 1'b1;
        end
      end else if (drain) begin
        vld_o  <= 1'b1;
        fcs_o  <= 1'b1;
        dout_o <= mem_q[0];
        last_o <= (occ_q == OW'(1));
        occ_q  <= occ_q - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk_i) begin
        if (push_i && (full || occ_q == OW'(i))) mem_q[i] <= din_i;
      end
    end else begin : g_mid
      always_ff @(posedge clk_i) begin
        if (push_i) begin
          if (full)                   mem_q[i] <= mem_q[i+1];
          else if (occ_q == OW'(i))   mem_q[i] <= din_i;
        end else if (drain) begin
          mem_q[i] <= mem_q[i+1];
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_parser.sv
module eth_rx_parser
  import eth_rx_pkg::*;
#(
  parameter int ADDR_OCTETS = 6,
  parameter int TYPE_OCTETS = 2,
  parameter int PRE_OCTETS  = 7,
  parameter int GAP_OCTETS  = 12,
  parameter int FCS_OCTETS  = 4,
  parameter int MIN_PAY     = 46,
  parameter int MAX_PAY     = 1500,
  parameter int CNT_W       = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_bit_i,
  input  logic                     rx_vld_i,
  output logic                     hdr_vld_o,
  output logic [8*ADDR_OCTETS-1:0] dst_addr_o,
  output logic [8*ADDR_OCTETS-1:0] src_addr_o,
  output logic [8*TYPE_OCTETS-1:0] type_len_o,
  output logic                     is_ipv4_o,
  output logic                     is_arp_o,
  output logic                     is_snap_o,
  output logic [7:0]               data_o,
  output logic                     data_vld_o,
  output logic                     data_fcs_o,
  output logic                     data_last_o,
  output logic                     data_err_o,
  output logic [CNT_W-1:0]         octet_cnt_o,
  output logic                     cnt_vld_o
);
  localparam int HDR_OCTETS = 2 * ADDR_OCTETS + TYPE_OCTETS;
  localparam int GAP_CLKS   = 8 * GAP_OCTETS;
  localparam int MIN_TOT    = HDR_OCTETS + MIN_PAY + FCS_OCTETS;
  localparam int MAX_TOT    = HDR_OCTETS + MAX_PAY + FCS_OCTETS;
  localparam int PW         = $clog2(PRE_OCTETS + 1);
  localparam int AW         = 8 * ADDR_OCTETS;
  localparam int TW         = 8 * TYPE_OCTETS;
  localparam int OW         = $clog2(FCS_OCTETS + 1);

  logic [7:0]       oct;
  logic             oct_vld, end_s, part_s, gap_done;
  logic             dly_last, push, err_now;
  logic [OW-1:0]    dly_occ;
  rx_state_e        state_q;
  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] idx_q;
  logic [AW-1:0]    dst_q, src_q;
  logic [TW-1:0]    type_q;
  logic             hdr_vld_q, ipv4_q, arp_q, snap_q, aa_q, err_q, cnt_vld_q;

  eth_rx_deser #(.W(8)) u_deser (
    .clk_i, .rst_ni, .bit_i(rx_bit_i), .vld_i(rx_vld_i),
    .oct_o(oct), .oct_vld_o(oct_vld), .end_o(end_s), .part_o(part_s)
  );

  eth_rx_gap #(.LIMIT(GAP_CLKS)) u_gap (
    .clk_i, .rst_ni, .vld_i(rx_vld_i), .done_o(gap_done)
  );

  assign push = (state_q == ST_BODY) && oct_vld && (idx_q >= CNT_W'(HDR_OCTETS));

  eth_rx_dly #(.DEPTH(FCS_OCTETS), .W(8)) u_dly (
    .clk_i, .rst_ni, .push_i(push), .din_i(oct),
    .flush_i((state_q == ST_BODY) && end_s),
    .dout_o(data_o), .vld_o(data_vld_o), .fcs_o(data_fcs_o),
    .last_o(dly_last), .occ_o(dly_occ)
  );

  assign err_now = part_s || (idx_q < CNT_W'(MIN_TOT)) || (idx_q > CNT_W'(MAX_TOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_GAP;
      pre_q     <= '0;
      idx_q     <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      type_q    <= '0;
      hdr_vld_q <= 1'b0;
      ipv4_q    <= 1'b0;
      arp_q     <= 1'b0;
      snap_q    <= 1'b0;
      aa_q      <= 1'b0;
      err_q     <= 1'b0;
      cnt_vld_q <= 1'b0;
    end else begin
      hdr_vld_q <= 1'b0;
      cnt_vld_q <= 1'b0;
      unique case (state_q)
        ST_GAP: begin
          pre_q <= '0;
          if (gap_done) state_q <= ST_HUNT;
        end
        ST_HUNT: begin
          if (end_s) begin
            state_q <= ST_GAP;
          end else if (oct_vld) begin
            if (oct == PRE_OCT && pre_q != PW'(PRE_OCTETS)) begin
              pre_q <= pre_q + 1'b1;
            end else if (oct == SFD_OCT && pre_q == PW'(PRE_OCTETS)) begin
              state_q <= ST_BODY;
              idx_q   <= '0;
              snap_q  <= 1'b0;
              aa_q    <= 1'b0;
              ipv4_q  <= 1'b0;
              arp_q   <= 1'b0;
            end else begin
              state_q <= ST_GAP;
            end
          end
        end
        ST_BODY: begin
          if (end_s) begin
            state_q   <= ST_GAP;
            err_q     <= err_now;
            cnt_vld_q <= (dly_occ == '0);
          end else if (oct_vld) begin
            if (idx_q != '1) idx_q <= idx_q + 1'b1;
            if (idx_q < CNT_W'(ADDR_OCTETS))
              dst_q <= {dst_q[AW-9:0], oct};
            else if (idx_q < CNT_W'(2 * ADDR_OCTETS))
              src_q <= {src_q[AW-9:0], oct};
            else if (idx_q < CNT_W'(HDR_OCTETS))
              type_q <= {type_q[TW-9:0], oct};
            if (idx_q == CNT_W'(HDR_OCTETS - 1)) begin
              hdr_vld_q <= 1'b1;
              ipv4_q    <= ({type_q[TW-9:0], oct} == TW'(TYPE_IPV4));
              arp_q     <= ({type_q[TW-9:0], oct} == TW'(TYPE_ARP));
            end
            if (idx_q == CNT_W'(HDR_OCTETS))     aa_q   <= (oct == SNAP_OCT);
            if (idx_q == CNT_W'(HDR_OCTETS + 1)) snap_q <= aa_q && (oct == SNAP_OCT);
          end
        end
        default: state_q <= ST_GAP;
      endcase
    end
  end

  assign hdr_vld_o   = hdr_vld_q;
  assign dst_addr_o  = dst_q;
  assign src_addr_o  = src_q;
  assign type_len_o  = type_q;
  assign is_ipv4_o   = ipv4_q;
  assign is_arp_o    = arp_q;
  assign is_snap_o   = snap_q;
  assign data_last_o = dly_last;
  assign octet_cnt_o = idx_q;
  assign cnt_vld_o   = cnt_vld_q || dly_last;
  assign data_err_o  = err_q && cnt_vld_o;
endmodule

// File: rtl/eth_rx_parser_chk.sv
module eth_rx_parser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hdr_vld_o,
  input logic is_ipv4_o,
  input logic is_arp_o,
  input logic data_vld_o,
  input logic data_fcs_o,
  input logic data_last_o,
  input logic data_err_o,
  input logic cnt_vld_o
);
  AST_LAST_IS_FCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_last_o |-> (data_vld_o && data_fcs_o)); // R7
  AST_FCS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_o && data_fcs_o && !data_last_o) |=> (data_vld_o && data_fcs_o)); // R7
  AST_QUIET_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_last_o |=> !data_vld_o); // R7
  AST_CNT_WITH_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_last_o |-> cnt_vld_o); // R8
  AST_ERR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_err_o |-> cnt_vld_o); // R9
  AST_CLASS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_ipv4_o && is_arp_o)); // R4
  AST_CNT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_vld_o |=> !cnt_vld_o); // R11
  AST_HDR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |=> !hdr_vld_o); // R11
endmodule

bind eth_rx_parser eth_rx_parser_chk u_chk (.*);

// File: tb/eth_rx_parser_tb.sv
module eth_rx_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 1600;

  logic clk_i = 1'b0, rst_ni = 1'b0, rx_bit_i = 1'b0, rx_vld_i = 1'b0;
  logic hdr_vld_o, is_ipv4_o, is_arp_o, is_snap_o;
  logic [47:0] dst_addr_o, src_addr_o;
  logic [15:0] type_len_o, octet_cnt_o;
  logic [7:0]  data_o;
  logic data_vld_o, data_fcs_o, data_last_o, data_err_o, cnt_vld_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  eth_rx_parser u_dut (.*);

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [7:0] fb [MAXF];

  int cap_n, cnt_seen, hdr_seen, cnt_val;
  logic [7:0] cap_d [MAXF];
  bit cap_f [MAXF], cap_l [MAXF];
  bit err_val, snap_val, h_v4, h_arp;
  logic [47:0] h_dst, h_src;
  logic [15:0] h_typ;

  always @(negedge clk_i) begin
    if (data_vld_o && cap_n < MAXF) begin
      cap_d[cap_n] = data_o; cap_f[cap_n] = data_fcs_o; cap_l[cap_n] = data_last_o;
      cap_n++;
    end
    if (cnt_vld_o) begin
      cnt_seen++; cnt_val = int'(octet_cnt_o); err_val = data_err_o; snap_val = is_snap_o;
    end
    if (hdr_vld_o) begin
      hdr_seen++; h_dst = dst_addr_o; h_src = src_addr_o; h_typ = type_len_o;
      h_v4 = is_ipv4_o; h_arp = is_arp_o;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear();
    cap_n = 0; cnt_seen = 0; hdr_seen = 0;
  endtask

  task automatic idle(int n);
    rx_vld_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_byte(logic [7:0] b, int nbits);
    for (int k = 0; k < nbits; k++) begin
      rx_vld_i = 1'b1; rx_bit_i = b[k];
      @(negedge clk_i);
    end
  endtask

  task automatic make_frame(int n, logic [15:0] typ, int snap_mode);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    fb[12] = typ[15:8]; fb[13] = typ[7:0];
    if (snap_mode == 1) begin fb[14] = 8'hAA; fb[15] = 8'hAA; end
    else if (snap_mode == 2) begin fb[14] = 8'hAA; fb[15] = 8'h03; end
    else fb[15] = fb[15] & 8'h7F;
  endtask

  task automatic send_frame(int n, int npre, logic [7:0] sfd, int extra_bits);
    for (int i = 0; i < npre; i++) send_byte(8'h55, 8);
    send_byte(sfd, 8);
    for (int i = 0; i < n; i++) send_byte(fb[i], 8);
    if (extra_bits > 0) send_byte(8'($urandom), extra_bits);
    rx_vld_i = 1'b0;
  endtask

  task automatic verify(int n, logic [15:0] typ, bit exp_err, string err_req, bit exp_snap);
    int nb = (n > 14) ? n - 14 : 0;
    int bad = -1;
    logic [47:0] ed = '0, es = '0;
    chk(cap_n == nb, "R6", "beat count", cap_n, nb);
    for (int i = 0; i < nb && i < cap_n; i++)
      if (bad < 0 && cap_d[i] != fb[14+i]) bad = i;
    chk(bad < 0, "R6", "first mismatching octet index", bad, -1);
    bad = -1;
    for (int i = 0; i < nb && i < cap_n; i++)
      if (bad < 0 && (cap_f[i] != (i >= nb - 4) || cap_l[i] != (i == nb - 1))) bad = i;
    chk(bad < 0, "R7", "first bad fcs/last tag index", bad, -1);
    chk(cnt_seen == 1 && cnt_val == n, "R8", "octet count", cnt_val, n);
    chk(err_val == exp_err, err_req, "error flag", err_val, exp_err);
    for (int k = 0; k < 6; k++) begin ed = {ed[39:0], fb[k]}; es = {es[39:0], fb[6+k]}; end
    chk(hdr_seen == 1 && h_dst == ed && h_src == es && h_typ == {fb[12], fb[13]},
        "R3", "header fields (dst low bits)", h_dst[15:0], ed[15:0]);
    chk(h_v4 == (typ == 16'h0800) && h_arp == (typ == 16'h0806),
        "R4", "class {ipv4,arp}", {h_v4, h_arp}, {typ == 16'h0800, typ == 16'h0806});
    chk(snap_val == exp_snap, "R5", "snap flag", snap_val, exp_snap);
  endtask

  task automatic run(int n, logic [15:0] typ, int snap_mode, bit exp_err, string req);
    clear();
    make_frame(n, typ, snap_mode);
    send_frame(n, 7, 8'hD5, 0);
    idle(120);
    verify(n, typ, exp_err, req, snap_mode == 1);
  endtask

  task automatic expect_silent(string req, string what);
    chk(cap_n == 0 && cnt_seen == 0 && hdr_seen == 0, req, what, cap_n + cnt_seen + hdr_seen, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear();
    repeat (3) @(negedge clk_i);
    chk(!data_vld_o && !hdr_vld_o && !cnt_vld_o && octet_cnt_o == 0 && !data_err_o,
        "R11", "outputs idle in reset", data_vld_o, 0);
    rst_ni = 1'b1;
    idle(120);

    run(64, 16'h0800, 0, 1'b0, "R9");     // min legal IPv4
    run(100, 16'h0806, 0, 1'b0, "R9");    // ARP
    run(80, 16'h0042, 1, 1'b0, "R9");     // SNAP
    run(80, 16'h0042, 2, 1'b0, "R9");     // single 0xAA: R5 negative
    run(63, 16'h0800, 0, 1'b1, "R9");     // one short
    run(1518, 16'h86DD, 0, 1'b0, "R9");   // max legal
    run(1519, 16'h0800, 0, 1'b1, "R9");   // one long

    // R10: valid lost three bits into an octet
    clear(); make_frame(70, 16'h0806, 0);
    send_frame(70, 7, 8'hD5, 3); idle(120);
    verify(70, 16'h0806, 1'b1, "R10", 1'b0);

    // R2: bad delimiter, short and long preambles
    clear(); make_frame(64, 16'h0800, 0); send_frame(64, 7, 8'h57, 0); idle(120);
    expect_silent("R2", "bad delimiter output");
    clear(); send_frame(64, 6, 8'hD5, 0); idle(120);
    expect_silent("R2", "six-octet preamble output");
    clear(); send_frame(64, 8, 8'hD5, 0); idle(120);
    expect_silent("R2", "eight-octet preamble output");

    // R1: 95 idle clocks is too few
    make_frame(64, 16'h0800, 0); send_frame(64, 7, 8'hD5, 0); idle(95);
    clear(); send_frame(64, 7, 8'hD5, 0); idle(120);
    expect_silent("R1", "frame after 95-clock gap");
    // R1: exactly 96 idle clocks re-arms
    send_frame(64, 7, 8'hD5, 0); idle(96);
    clear(); make_frame(72, 16'h0806, 0); send_frame(72, 7, 8'hD5, 0); idle(120);
    chk(cnt_seen == 1 && cnt_val == 72, "R1", "frame after 96-clock gap count", cnt_val, 72);

    // random frames
    for (int t = 0; t < 6; t++) begin
      int n = 64 + int'($urandom % 120);
      int sel = int'($urandom % 3);
      logic [15:0] typ = (sel == 0) ? 16'h0800 : (sel == 1) ? 16'h0806 : 16'h0600;
      run(n, typ, int'($urandom % 3), 1'b0, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule